// File: doc/BRIEF.md
# Sign-Bit Normalization Counter

This block reports how many places a signed two's-complement operand can be moved left before its most significant value bit reaches the position just under the sign bit. In other words, it counts the redundant copies of the sign at the top of the word. Fixed-point datapaths use this count to scale a value to full precision ahead of a division, a square root or a block-exponent step. The block does not apply the shift itself.

A select input chooses between a narrow operand, held in the low 16 bits of the operand bus, and a full 32-bit operand. The count is formed combinationally by a binary search over halves, quarters and so on of a folded copy of the operand. The result is captured in a register when the load enable is high. Downstream logic reads it one clock after the operand is presented.

Top module: `sign_norm_counter`

## Requirements
- R1: A synchronous active-low reset clears the count register to 0, whatever the enable and operand inputs are.
- R2: With `load_en` high, the count for the operand and mode present at a rising edge appears on `count_q` after that edge. With `load_en` low, `count_q` keeps its value.
- R3: An operand of zero gives a count of 0 in both modes (narrow: `operand[15:0]` == 0; wide: `operand` == 0).
- R4: An operand of minus one gives 15 in narrow mode (`operand[15:0]` == 16'hFFFF) and 31 in wide mode (`operand` == 32'hFFFFFFFF).
- R5: A negative operand (sign bit 15 in narrow mode, bit 31 in wide mode) is bitwise complemented before counting. Its count therefore equals the count of its complement.
- R6: Narrow mode is selected by `wide_sel` = 0. Only `operand[15:0]` is used, and bits 31:16 have no effect. The count is the number of left shifts the folded 16-bit value needs to reach at least 16'h4000.
- R7: Wide mode is selected by `wide_sel` = 1. For an operand other than zero, the count equals the number of leading zeros of the folded 32-bit value, minus one.
- R8: For any operand other than zero or minus one, a left shift by the count keeps the sign bit unchanged. The bit just below the sign then differs from the sign, so one more shift would change the sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Capture the new count at this edge |
| wide_sel | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand in bits 15:0 |
| operand | input | 32 | Signed two's-complement operand |
| count_q | output | 5 | Registered normalization count |

## Verification
The bench builds the block with its default parameters: a 32-bit wide operand, a 16-bit narrow operand and a 5-bit count. This makes both modes and their full count ranges (0 to 15 and 0 to 31) reachable. A table walks the zero, minus-one, single-bit, most-negative and most-positive operands, and also a narrow operand carrying garbage in its upper half. A pseudo-random sweep in both modes then compares each result with a shift-until-normalized reference loop. The same sweep checks that the sign is preserved and that the count is maximal. Directed steps cover reset during a load and holding the count with the enable low.

// File: rtl/nrm_pkg.sv
// Package: shared widths for the sign-bit normalization counter.
// Assumes the wide width is a power of two and larger than the narrow width.
package nrm_pkg;
    parameter int unsigned NRM_WIDE_W   = 32;
    parameter int unsigned NRM_NARROW_W = 16;
    localparam int unsigned NRM_CNT_W   = $clog2(NRM_WIDE_W);
endpackage

// File: rtl/nrm_fold.sv
// Module: nrm_fold
// Folds the operand so that only redundant sign bits stay on top as zeros.
// Negative values are complemented. The result is then packed into a
// WIDE_W search word whose leading-zero count is the normalization count.
// A guard '1' below the useful bits caps the count at width-1. This makes
// minus one (folded to zero) give 15 or 31 naturally.
// Assumes NARROW_W < WIDE_W. The zero operand is flagged separately.
module nrm_fold #(
    parameter int unsigned WIDE_W   = nrm_pkg::NRM_WIDE_W,
    parameter int unsigned NARROW_W = nrm_pkg::NRM_NARROW_W
) (
    input  logic              wide_sel,
    input  logic [WIDE_W-1:0] operand,
    output logic [WIDE_W-1:0] search_word,
    output logic              is_zero
);
    localparam int unsigned PAD_W = WIDE_W - NARROW_W;

    logic [NARROW_W-1:0] narrow_v;
    logic [NARROW_W-1:0] fold_n;
    logic [WIDE_W-1:0]   fold_w;
    logic [WIDE_W-1:0]   pack_n;
    logic [WIDE_W-1:0]   pack_w;
    logic                unused_sign_bits;

    assign narrow_v = operand[NARROW_W-1:0];

    // Complement negative operands in each width (sign fold).
    always_comb begin
        fold_n = narrow_v[NARROW_W-1] ? ~narrow_v : narrow_v;
        fold_w = operand[WIDE_W-1]    ? ~operand  : operand;
    end

    // After folding, the sign positions are always zero, so they take no part.
    assign unused_sign_bits = fold_n[NARROW_W-1] ^ fold_w[WIDE_W-1];

    // Pack each width with a guard bit directly under its value bits.
    always_comb begin
        pack_w = {fold_w[WIDE_W-2:0], 1'b1};
        pack_n = {fold_n[NARROW_W-2:0], 1'b1, {PAD_W{1'b0}}};
    end

    // Choose the active width and detect the all-zero operand.
    always_comb begin
        search_word = wide_sel ? pack_w : pack_n;
        is_zero     = wide_sel ? (operand == '0) : (narrow_v == '0);
    end
endmodule

// File: rtl/nrm_search_stage.sv
// Module: nrm_search_stage
// One step of the leading-zero binary search. If the top STEP bits of the
// word are all zero, the word moves left by STEP and STEP is added to the
// running count. Purely combinational. Assumes STEP < W.
module nrm_search_stage #(
    parameter int unsigned W     = 32,
    parameter int unsigned STEP  = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic [W-1:0]     word_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [W-1:0]     word_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic hit;

    // Test the upper window of this step.
    assign hit = (word_i[W-1 -: STEP] == '0);

    // Shift out the zero window and account for it.
    always_comb begin
        word_o = hit ? (word_i << STEP) : word_i;
        cnt_o  = cnt_i + (hit ? CNT_W'(STEP) : '0);
    end
endmodule

// File: rtl/nrm_lead_search.sv
// Module: nrm_lead_search
// Leading-zero counter built as a chain of halving steps (W/2, W/4 ... 1).
// Assumes W is a power of two and word is non-zero, which the fold's
// guard bit ensures. The result then lies in 0..W-1.
module nrm_lead_search #(
    parameter int unsigned W     = nrm_pkg::NRM_WIDE_W,
    parameter int unsigned CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     word,
    output logic [CNT_W-1:0] lead_cnt
);
    localparam int unsigned LEVELS = $clog2(W);

    logic [W-1:0]     word_chain [LEVELS+1];
    logic [CNT_W-1:0] cnt_chain  [LEVELS+1];
    logic             unused_tail;

    assign word_chain[0] = word;
    assign cnt_chain[0]  = '0;

    // One stage for each power of two, largest step first.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_step
        nrm_search_stage #(
            .W    (W),
            .STEP (1 << (LEVELS - 1 - lv)),
            .CNT_W(CNT_W)
        ) u_stage (
            .word_i(word_chain[lv]),
            .cnt_i (cnt_chain[lv]),
            .word_o(word_chain[lv+1]),
            .cnt_o (cnt_chain[lv+1])
        );
    end

    assign lead_cnt    = cnt_chain[LEVELS];
    assign unused_tail = ^word_chain[LEVELS];
endmodule

// File: rtl/sign_norm_counter.sv
// Module: sign_norm_counter (top)
// Counts the redundant sign bits of a 16-bit or 32-bit signed operand and
// registers the count behind a load enable. Zero yields 0. Every other value,
// including minus one, follows the fold-and-search path.
// Synchronous active-low reset. Assumes WIDE_W is a power of two > NARROW_W.
module sign_norm_counter #(
    parameter int unsigned WIDE_W   = nrm_pkg::NRM_WIDE_W,
    parameter int unsigned NARROW_W = nrm_pkg::NRM_NARROW_W,
    localparam int unsigned CNT_W   = $clog2(WIDE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              wide_sel,
    input  logic [WIDE_W-1:0] operand,
    output logic [CNT_W-1:0]  count_q
);
    logic [WIDE_W-1:0] search_word;
    logic              is_zero;
    logic [CNT_W-1:0]  lead_cnt;
    logic [CNT_W-1:0]  count_d;

    nrm_fold #(
        .WIDE_W  (WIDE_W),
        .NARROW_W(NARROW_W)
    ) u_fold (
        .wide_sel   (wide_sel),
        .operand    (operand),
        .search_word(search_word),
        .is_zero    (is_zero)
    );

    nrm_lead_search #(
        .W    (WIDE_W),
        .CNT_W(CNT_W)
    ) u_search (
        .word    (search_word),
        .lead_cnt(lead_cnt)
    );

    // Zero has no sign bit to normalize against and is forced to 0.
    assign count_d = is_zero ? '0 : lead_cnt;

    // Count register: cleared by reset, loaded when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= count_d;
        end
    end
endmodule

// File: rtl/nrm_checker.sv
// Module: nrm_checker
// Property checker for sign_norm_counter, attached by bind. It keeps
// registered copies of the load inputs so that the registered count can be
// related to the operand that produced it.
module nrm_checker #(
    parameter int unsigned WIDE_W   = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned CNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              wide_sel,
    input logic [WIDE_W-1:0] operand,
    input logic [CNT_W-1:0]  count_q
);
    logic [WIDE_W-1:0]   op_q;
    logic                wide_q;
    logic                en_q;
    logic [WIDE_W-1:0]   shift_w;
    logic [NARROW_W-1:0] shift_n;

    // Remember the last loaded operand and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            wide_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            op_q   <= operand;
            wide_q <= wide_sel;
            en_q   <= load_en;
        end
    end

    // Apply the reported count to the remembered operand.
    always_comb begin
        shift_w = op_q << count_q;
        shift_n = op_q[NARROW_W-1:0] << count_q;
    end

    // R1: the first cycle out of reset shows a cleared count
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count_q == '0);

    // R2: the count holds while the enable is low
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(count_q));

    // R3: a zero operand loads 0
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && (wide_sel ? (operand == '0) : (operand[NARROW_W-1:0] == '0))
        |=> count_q == '0);

    // R4: minus one loads the largest count of its width
    p_minus_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && wide_sel && (operand == '1) |=> count_q == CNT_W'(WIDE_W - 1));
    p_minus_one_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && !wide_sel && (operand[NARROW_W-1:0] == '1)
        |=> count_q == CNT_W'(NARROW_W - 1));

    // R6: a narrow count never exceeds narrow width minus one
    p_narrow_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && !wide_sel |=> count_q <= CNT_W'(NARROW_W - 1));

    // R8: the shift keeps the sign and leaves the operand normalized
    p_sign_kept_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && wide_q && (op_q != '0) && (op_q != '1)
        |-> (shift_w[WIDE_W-1] == op_q[WIDE_W-1]) &&
            (shift_w[WIDE_W-2] != op_q[WIDE_W-1]));
    p_sign_kept_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !wide_q && (op_q[NARROW_W-1:0] != '0) && (op_q[NARROW_W-1:0] != '1)
        |-> (shift_n[NARROW_W-1] == op_q[NARROW_W-1]) &&
            (shift_n[NARROW_W-2] != op_q[NARROW_W-1]));
endmodule

bind sign_norm_counter nrm_checker #(
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .wide_sel(wide_sel),
    .operand (operand),
    .count_q (count_q)
);

// File: tb/sim_sign_norm_counter.sv
`timescale 1ns/1ps
module sim_sign_norm_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        wide_sel = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  count_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sign_norm_counter u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .wide_sel(wide_sel),
        .operand (operand),
        .count_q (count_q)
    );

    typedef struct packed {
        logic        wide;
        logic [31:0] op;
        logic [4:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0000_0000, 5'd0,  4'd3},  // R3 narrow zero
        '{1'b1, 32'h0000_0000, 5'd0,  4'd3},  // R3 wide zero
        '{1'b0, 32'h0000_FFFF, 5'd15, 4'd4},  // R4 narrow minus one
        '{1'b1, 32'hFFFF_FFFF, 5'd31, 4'd4},  // R4 wide minus one
        '{1'b0, 32'h0000_4000, 5'd0,  4'd6},  // R6 already normalized
        '{1'b0, 32'h0000_0001, 5'd14, 4'd6},  // R6 smallest positive
        '{1'b0, 32'h0000_7FFF, 5'd0,  4'd6},  // R6 most positive
        '{1'b0, 32'h0000_0100, 5'd6,  4'd6},  // R6 single bit
        '{1'b0, 32'hABCD_0003, 5'd13, 4'd6},  // R6 upper half ignored
        '{1'b0, 32'h0000_8000, 5'd0,  4'd5},  // R5 most negative narrow
        '{1'b0, 32'h0000_C000, 5'd1,  4'd5},  // R5 folds to 3FFF
        '{1'b0, 32'h0000_FFFE, 5'd14, 4'd5},  // R5 folds to 1
        '{1'b1, 32'h0000_0001, 5'd30, 4'd7},  // R7 smallest positive
        '{1'b1, 32'h4000_0000, 5'd0,  4'd7},  // R7 normalized
        '{1'b1, 32'h7FFF_FFFF, 5'd0,  4'd7},  // R7 most positive
        '{1'b1, 32'h0000_8000, 5'd15, 4'd7},  // R7 low half crossing
        '{1'b1, 32'h0001_0000, 5'd14, 4'd7},  // R7 upper half
        '{1'b1, 32'h0000_FFFF, 5'd15, 4'd7},  // R7 low half full
        '{1'b1, 32'h8000_0000, 5'd0,  4'd5},  // R5 most negative wide
        '{1'b1, 32'hFFFF_FFFE, 5'd30, 4'd5},  // R5 folds to 1
        '{1'b1, 32'hC000_0000, 5'd1,  4'd5},  // R5 folds to 3FFFFFFF
        '{1'b1, 32'hFFFF_0000, 5'd15, 4'd5}   // R5 folds to 0000FFFF
    };

    // Reference: shift the folded value until it reaches the quarter-scale mark.
    function automatic int ref_count(input logic wide, input logic [31:0] op);
        longint v;
        longint f;
        longint mark;
        int     n;
        int     w;
        w = wide ? 32 : 16;
        v = wide ? longint'($signed(op)) : longint'($signed(op[15:0]));
        if (v == 0) return 0;
        if (v == -1) return w - 1;
        f = (v < 0) ? (-v - 1) : v;
        mark = longint'(1) << (w - 2);
        n = 0;
        while (f < mark) begin
            f = f << 1;
            n++;
        end
        return n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one operand with the enable high; sample after the loading edge.
    task automatic apply(input logic wide, input logic [31:0] op);
        @(negedge clk);
        wide_sel = wide;
        operand  = op;
        load_en  = 1'b1;
        @(negedge clk);
        load_en  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        int          prev;
        rst_n = 1'b0;
        load_en = 1'b1;
        operand = 32'h0000_0001;
        wide_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(count_q), 0);
        rst_n = 1'b1;
        load_en = 1'b0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].wide, VECS[i].op);
            check($sformatf("R%0d vector %0d op %h", VECS[i].req, i, VECS[i].op),
                  int'(count_q), int'(VECS[i].exp));
        end

        // R2: enable low holds the count
        apply(1'b1, 32'h0000_0001);
        prev = int'(count_q);
        @(negedge clk);
        operand = 32'h4000_0000;
        wide_sel = 1'b1;
        load_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold with enable low", int'(count_q), prev);
        check("R2 held value", prev, 30);

        // R1: reset while enable is high clears the count
        @(negedge clk);
        operand = 32'h0000_0001;
        load_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset overrides load", int'(count_q), 0);
        rst_n = 1'b1;
        load_en = 1'b0;

        // R6: upper half changes have no effect in narrow mode
        apply(1'b0, 32'h0000_0020);
        check("R6 narrow base", int'(count_q), 9);
        apply(1'b0, 32'hFFFF_0020);
        check("R6 narrow upper ones ignored", int'(count_q), 9);

        // R8 sweep against the reference loop in both modes
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 600; k++) begin
            logic [31:0] op;
            logic        wd;
            int          e;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op = lfsr >> (k % 29);
            if (k % 3 == 0) op = ~op;
            wd = k[0];
            e = ref_count(wd, op);
            apply(wd, op);
            check($sformatf("R8 sweep op %h wide %0d", op, wd), int'(count_q), e);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule